// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that executes a chain of transfer descriptors held in memory. Each descriptor takes four aligned 32-bit words: a link word first, then the source address, the destination address and a command word. Software loads the address of the first descriptor and sets the run bit. The channel then reads the descriptor, moves the byte count that the command word gives, and follows the link word to the next descriptor. It halts after a descriptor whose link word has bit 0 set.

Data moves in beats. Each beat is a read from the source followed by a write to the destination, both of the width that the command selects. The command word also chooses whether each address advances and whether the transfer is paced by a peripheral request line. A paced transfer moves one burst for each request it sees. The channel can also run a single transfer from its own source, destination and command registers without fetching any descriptor. Start, end, error and stop conditions merge into one interrupt output.

Top module: `ldma_chan`

## Requirements
- R1: After reset the status register (word 0) reads 0x00000008 (only the stop-state bit 3 set), irq is low and no memory request is made.
- R2: On start the channel reads four words, in the order link, source, destination, command, from addresses base+0, +4, +8 and +12. The base is the descriptor-address register (word 1) with bits [3:0] forced to zero, and every descriptor read is a word access (mem_size 2).
- R3: Each data beat reads from the source and then writes the same bytes to the destination. The beat size follows command bits [15:14]: 1 gives 1 byte, 2 gives 2 bytes, 3 or 0 gives 4 bytes. The number of write beats is the length in command bits [12:0] divided by the beat size.
- R4: Command bit 31 advances the source address by the beat size after each beat, and bit 30 does the same for the destination. With a bit clear, that address stays fixed.
- R5: After a descriptor completes, the channel fetches the next one at the link word (bits [31:4]) unless the link's bit 0 is set. In that case it stops: run (bit 31) clears and stop-state (bit 3) sets.
- R6: Command bit 22 sets status bit 1 when the descriptor starts, and bit 21 sets status bit 2 when it ends. irq is high while any flag is set, and writing 1 to a flag bit clears it.
- R7: An error response on a descriptor read or a data beat sets status bit 0, stops the channel at once and raises irq.
- R8: Command bit 29 paces the transfer by src_req and bit 28 by tgt_req. No data beat starts while the selected request is low. Each request seen moves one burst, whose size follows command bits [17:16]: 1 or 0 gives 8 bytes, 2 gives 16 bytes, 3 gives 32 bytes. The channel then waits again.
- R9: Writing 0 to run while the channel is active aborts it. The channel stops and makes no further memory requests.
- R10: A write to the descriptor-address register while the channel is running is ignored.
- R11: With status bit 30 set in the same write that sets run, the channel fetches no descriptor. It runs one transfer from registers 2 (source), 3 (destination) and 4 (command), then stops.
- R12: With status bit 29 set, irq is high while the channel is stopped.
- R13: A descriptor with length 0 makes no data beat, still completes, and still raises its end flag.
- R14: Status bit 8 reads 1 while the channel is running and the request line selected by the command is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select: 0 status, 1 descriptor address, 2 source, 3 destination, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | 32 | Write data, low lanes valid |
| mem_ack | input | 1 | Memory completes the current request |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| src_req | input | 1 | Source peripheral request |
| tgt_req | input | 1 | Destination peripheral request |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest state to reach from the ports is a paced transfer parked between bursts. The bench must hold the request low long enough to show that nothing moves. It then raises the request for exactly one cycle, reads request-pending in the same half cycle, and counts that precisely one burst of writes follows. Errors are injected on one chosen address, once in the middle of a descriptor fetch and once on a data read. Randomly sized copies with random widths check the byte contents, the beat count, and an untouched guard byte past the end of each copy.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int WORD = 32;

  localparam int CMD_INC_SRC   = 31;
  localparam int CMD_INC_TGT   = 30;
  localparam int CMD_PACE_SRC  = 29;
  localparam int CMD_PACE_TGT  = 28;
  localparam int CMD_IRQ_START = 22;
  localparam int CMD_IRQ_END   = 21;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_WAIT, S_READ, S_WRITE, S_DONE
  } eng_st_t;

  // bytes per beat from the width code
  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // memory size code for a width code
  function automatic logic [1:0] size_code(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // bytes per request-paced burst
  function automatic logic [5:0] burst_bytes(input logic [1:0] code);
    case (code)
      2'd2:    return 6'd16;
      2'd3:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction
endpackage

// File: rtl/ldma_engine.sv
module ldma_engine
  import ldma_pkg::*;
#(
  parameter int LW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            nofetch,
  input  logic            abort,
  input  logic            wr_ptr,
  input  logic            wr_src,
  input  logic            wr_tgt,
  input  logic            wr_cmd,
  input  logic [WORD-1:0] wdata,
  input  logic            src_req,
  input  logic            tgt_req,
  output logic            mem_req,
  output logic            mem_we,
  output logic [WORD-1:0] mem_addr,
  output logic [1:0]      mem_size,
  output logic [WORD-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [WORD-1:0] mem_rdata,
  output logic [WORD-1:0] ptr_q,
  output logic [WORD-1:0] src_q,
  output logic [WORD-1:0] tgt_q,
  output logic [WORD-1:0] cmd_q,
  output logic            idle,
  output logic            req_pend,
  output logic            ev_start,
  output logic            ev_end,
  output logic            ev_err,
  output logic            ev_halt
);
  eng_st_t             st;
  logic [WORD-1:4]     base_q;
  logic [1:0]          widx_q;
  logic [LW-1:0]       rem_q;
  logic [5:0]          bleft_q;
  logic                last_q;
  logic [WORD-1:0]     buf_q;

  logic                hs, flow, req_sel;
  logic [2:0]          w;
  logic [LW-1:0]       rem_nx;

  assign hs      = mem_req & mem_ack;
  assign w       = beat_bytes(cmd_q[15:14]);
  assign flow    = cmd_q[CMD_PACE_SRC] | cmd_q[CMD_PACE_TGT];
  assign req_sel = (cmd_q[CMD_PACE_SRC] & src_req) | (cmd_q[CMD_PACE_TGT] & tgt_req);
  assign rem_nx  = (rem_q > LW'(w)) ? rem_q - LW'(w) : '0;

  assign idle      = (st == S_IDLE);
  assign req_pend  = ~idle & req_sel;
  assign mem_req   = (st == S_FETCH) | (st == S_READ) | (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_size  = (st == S_FETCH) ? 2'd2 : size_code(cmd_q[15:14]);
  assign mem_wdata = buf_q;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = {base_q, widx_q, 2'b00};
      S_WRITE: mem_addr = tgt_q;
      default: mem_addr = src_q;
    endcase
  end

  assign ev_start = (st == S_LOAD) & cmd_q[CMD_IRQ_START];
  assign ev_end   = (st == S_DONE) & cmd_q[CMD_IRQ_END];
  assign ev_err   = hs & mem_err;
  assign ev_halt  = ((st == S_DONE) & last_q) | ev_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      widx_q  <= '0;
      rem_q   <= '0;
      bleft_q <= '0;
      last_q  <= 1'b0;
      buf_q   <= '0;
      ptr_q   <= '0;
      src_q   <= '0;
      tgt_q   <= '0;
      cmd_q   <= '0;
    end else if (abort && st != S_IDLE) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_ptr) ptr_q <= wdata;
          if (wr_src) src_q <= wdata;
          if (wr_tgt) tgt_q <= wdata;
          if (wr_cmd) cmd_q <= wdata;
          if (go) begin
            if (nofetch) begin
              last_q <= 1'b1;
              st     <= S_LOAD;
            end else begin
              base_q <= ptr_q[WORD-1:4];
              widx_q <= '0;
              st     <= S_FETCH;
            end
          end
        end
        S_FETCH: if (hs) begin
          if (mem_err) st <= S_IDLE;
          else begin
            case (widx_q)
              2'd0: begin ptr_q <= mem_rdata; last_q <= mem_rdata[0]; end
              2'd1: src_q <= mem_rdata;
              2'd2: tgt_q <= mem_rdata;
              default: cmd_q <= mem_rdata;
            endcase
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd3) st <= S_LOAD;
          end
        end
        S_LOAD: begin
          rem_q <= cmd_q[LW-1:0];
          if (cmd_q[LW-1:0] == '0) st <= S_DONE;
          else if (flow)           st <= S_WAIT;
          else                     st <= S_READ;
        end
        S_WAIT: if (req_sel) begin
          bleft_q <= burst_bytes(cmd_q[17:16]);
          st      <= S_READ;
        end
        S_READ: if (hs) begin
          if (mem_err) st <= S_IDLE;
          else begin
            buf_q <= mem_rdata;
            if (cmd_q[CMD_INC_SRC]) src_q <= src_q + WORD'(w);
            st <= S_WRITE;
          end
        end
        S_WRITE: if (hs) begin
          if (mem_err) st <= S_IDLE;
          else begin
            if (cmd_q[CMD_INC_TGT]) tgt_q <= tgt_q + WORD'(w);
            rem_q <= rem_nx;
            if (rem_nx == '0)                      st <= S_DONE;
            else if (flow && bleft_q <= 6'(w))     st <= S_WAIT;
            else begin
              bleft_q <= bleft_q - 6'(w);
              st      <= S_READ;
            end
          end
        end
        S_DONE: begin
          if (last_q) st <= S_IDLE;
          else begin
            base_q <= ptr_q[WORD-1:4];
            widx_q <= '0;
            st     <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));
  // R7
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> idle);
  // R8
  pace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !req_sel && !abort) |=> !mem_req);
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !mem_req);
endmodule

// File: rtl/ldma_csr.sv
module ldma_csr
  import ldma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [5:0]      stat_wbits,
  output logic [WORD-1:0] reg_rdata,
  input  logic [WORD-1:0] ptr_q,
  input  logic [WORD-1:0] src_q,
  input  logic [WORD-1:0] tgt_q,
  input  logic [WORD-1:0] cmd_q,
  input  logic            idle,
  input  logic            req_pend,
  input  logic            ev_start,
  input  logic            ev_end,
  input  logic            ev_err,
  input  logic            ev_halt,
  output logic            go,
  output logic            nofetch,
  output logic            abort,
  output logic            wr_ptr,
  output logic            wr_src,
  output logic            wr_tgt,
  output logic            wr_cmd,
  output logic            irq
);
  // stat_wbits = {run, nofetch, stop_irq_en, end_clr, start_clr, err_clr}
  logic run_q, nof_q, sten_q, f_end, f_start, f_err;
  logic wr_stat;

  assign wr_stat = reg_wr & (reg_addr == 3'd0);
  assign wr_ptr  = reg_wr & (reg_addr == 3'd1);
  assign wr_src  = reg_wr & (reg_addr == 3'd2);
  assign wr_tgt  = reg_wr & (reg_addr == 3'd3);
  assign wr_cmd  = reg_wr & (reg_addr == 3'd4);

  assign go      = wr_stat & stat_wbits[5] & ~run_q & idle;
  assign abort   = wr_stat & ~stat_wbits[5] & run_q;
  assign nofetch = wr_stat ? stat_wbits[4] : nof_q;
  assign irq     = f_end | f_start | f_err | (sten_q & idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; nof_q <= 1'b0; sten_q <= 1'b0;
      f_end <= 1'b0; f_start <= 1'b0; f_err <= 1'b0;
    end else begin
      if (go)           run_q <= 1'b1;
      else if (abort)   run_q <= 1'b0;
      else if (ev_halt) run_q <= 1'b0;
      if (wr_stat) begin
        nof_q  <= stat_wbits[4];
        sten_q <= stat_wbits[3];
      end
      f_end   <= (f_end   & ~(wr_stat & stat_wbits[2])) | ev_end;
      f_start <= (f_start & ~(wr_stat & stat_wbits[1])) | ev_start;
      f_err   <= (f_err   & ~(wr_stat & stat_wbits[0])) | ev_err;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {run_q, nof_q, sten_q, 20'd0, req_pend, 4'd0,
                         idle, f_end, f_start, f_err};
      3'd1: reg_rdata = ptr_q;
      3'd2: reg_rdata = src_q;
      3'd3: reg_rdata = tgt_q;
      3'd4: reg_rdata = cmd_q;
      default: reg_rdata = '0;
    endcase
  end

  // R6
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> irq);
  // R5
  halt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_halt && !go) |=> !run_q);
endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
  import ldma_pkg::*;
#(
  parameter int LW = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        src_req,
  input  logic        tgt_req,
  output logic        irq
);
  logic go, nofetch, abort, wr_ptr, wr_src, wr_tgt, wr_cmd;
  logic idle, req_pend, ev_start, ev_end, ev_err, ev_halt;
  logic [WORD-1:0] ptr_q, src_q, tgt_q, cmd_q;

  ldma_engine #(.LW(LW)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .nofetch(nofetch), .abort(abort),
    .wr_ptr(wr_ptr), .wr_src(wr_src), .wr_tgt(wr_tgt), .wr_cmd(wr_cmd),
    .wdata(reg_wdata), .src_req(src_req), .tgt_req(tgt_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata),
    .ptr_q(ptr_q), .src_q(src_q), .tgt_q(tgt_q), .cmd_q(cmd_q),
    .idle(idle), .req_pend(req_pend), .ev_start(ev_start),
    .ev_end(ev_end), .ev_err(ev_err), .ev_halt(ev_halt)
  );

  ldma_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .stat_wbits({reg_wdata[31:29], reg_wdata[2:0]}), .reg_rdata(reg_rdata),
    .ptr_q(ptr_q), .src_q(src_q), .tgt_q(tgt_q), .cmd_q(cmd_q),
    .idle(idle), .req_pend(req_pend), .ev_start(ev_start),
    .ev_end(ev_end), .ev_err(ev_err), .ev_halt(ev_halt),
    .go(go), .nofetch(nofetch), .abort(abort),
    .wr_ptr(wr_ptr), .wr_src(wr_src), .wr_tgt(wr_tgt), .wr_cmd(wr_cmd),
    .irq(irq)
  );
endmodule

// File: tb/ldma_chan_bench.sv
module ldma_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RUN   = 32'h8000_0000;
  localparam logic [31:0] INC_S = 32'h8000_0000;
  localparam logic [31:0] INC_T = 32'h4000_0000;
  localparam logic [31:0] PC_S  = 32'h2000_0000;
  localparam logic [31:0] PC_T  = 32'h1000_0000;
  localparam logic [31:0] IE_S  = 32'h0040_0000;
  localparam logic [31:0] IE_E  = 32'h0020_0000;
  localparam logic [31:0] BU8   = 32'h0001_0000;
  localparam logic [31:0] WD4   = 32'h0000_C000;
  localparam logic [31:0] WD2   = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        src_req = 1'b0, tgt_req = 1'b0, irq;

  logic [7:0]  mem [0:4095];
  logic [31:0] log_addr [0:255];
  logic        log_we [0:255];
  int          nlog = 0;
  logic        inject = 1'b0;
  logic [31:0] err_addr = '0;
  int          errors = 0, checks = 0;

  ldma_chan u_ldma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .src_req(src_req), .tgt_req(tgt_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] get_word(input logic [31:0] a);
    int i;
    i = int'(a[11:0]);
    return {mem[i+3], mem[i+2], mem[i+1], mem[i]};
  endfunction

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) mem[int'(a[11:0]) + b] = d[8*b +: 8];
  endtask

  task automatic desc(input logic [31:0] a, input logic [31:0] nxt,
                      input logic [31:0] s, input logic [31:0] t, input logic [31:0] c);
    put_word(a, nxt); put_word(a + 4, s); put_word(a + 8, t); put_word(a + 12, c);
  endtask

  task automatic rwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rrd(3'd0, s);
      if (s[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic run_chain(input logic [31:0] p);
    nlog = 0;
    rwr(3'd1, p);
    rwr(3'd0, RUN);
    wait_stop();
  endtask

  function automatic int count_writes();
    int n;
    n = 0;
    for (int i = 0; i < nlog && i < 256; i++) if (log_we[i]) n++;
    return n;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, n0;
    int c, w, nb, len, sa, ta, bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);

    fork
      forever begin
        @(negedge clk);
        if (mem_ack) begin
          mem_ack = 1'b0; mem_err = 1'b0;
        end else if (mem_req) begin
          if (nlog < 256) begin log_addr[nlog] = mem_addr; log_we[nlog] = mem_we; end
          nlog++;
          if (inject && mem_addr == err_addr) mem_err = 1'b1;
          else if (mem_we)
            for (int b = 0; b < (1 << mem_size); b++)
              mem[int'(mem_addr[11:0]) + b] = mem_wdata[8*b +: 8];
          else mem_rdata = get_word(mem_addr);
          mem_ack = 1'b1;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rrd(3'd0, s);
    check("R1 reset status", s, 32'h8);
    check("R1 reset irq", 32'(irq), 32'h0);
    check("R1 reset mem_req", 32'(mem_req), 32'h0);

    // directed two-descriptor chain
    desc(32'h100, 32'h110, 32'h200, 32'h300, INC_S | INC_T | WD4 | IE_S | 32'd8);
    desc(32'h110, 32'h1,   32'h208, 32'h308, INC_S | INC_T | WD2 | IE_E | 32'd6);
    run_chain(32'h10C);
    check("R2 fetch word 0 address", log_addr[0], 32'h100);
    check("R2 fetch word 1 address", log_addr[1], 32'h104);
    check("R2 fetch word 2 address", log_addr[2], 32'h108);
    check("R2 fetch word 3 address", log_addr[3], 32'h10C);
    check("R3 first beat reads source", log_addr[4], 32'h200);
    check("R5 second descriptor fetched from link", log_addr[8], 32'h110);
    check("R3 chain copy word 0", get_word(32'h300), get_word(32'h200));
    check("R3 chain copy word 2", get_word(32'h308), get_word(32'h208));
    check("R3 chain copy halfword tail", 32'({mem[13'h30D], mem[13'h30C]}), 32'({mem[13'h20D], mem[13'h20C]}));
    check("R3 chain write beats", count_writes(), 32'd5);
    rrd(3'd0, s);
    check("R5 R6 status after chain", s, 32'hE);
    check("R6 irq raised", 32'(irq), 32'h1);
    rrd(3'd1, s);
    check("R5 link register holds stop link", s, 32'h1);
    rwr(3'd0, 32'h6);
    rrd(3'd0, s);
    check("R6 flags cleared by write-one", s, 32'h8);
    check("R6 irq dropped", 32'(irq), 32'h0);

    // random copies
    for (int it = 0; it < 6; it++) begin
      c = int'($urandom_range(1, 3));
      w = (c == 3) ? 4 : c;
      nb = int'($urandom_range(1, 8));
      len = nb * w;
      sa = 32'h800 + 4 * int'($urandom_range(0, 15));
      ta = 32'hC00 + 4 * int'($urandom_range(0, 15));
      for (int b = 0; b < len; b++) mem[sa + b] = 8'($urandom);
      for (int b = 0; b < len + 4; b++) mem[ta + b] = 8'hEE;
      desc(32'h120, 32'h1, sa, ta, INC_S | INC_T | (32'(c) << 14) | 32'(len));
      run_chain(32'h120);
      bad = 0;
      for (int b = 0; b < len; b++) if (mem[ta + b] !== mem[sa + b]) bad++;
      check("R3 random copy byte mismatches", bad, 0);
      check("R3 random write beat count", count_writes(), len / w);
      check("R3 guard byte untouched", 32'(mem[ta + len]), 32'hEE);
    end

    // fixed destination
    desc(32'h160, 32'h1, 32'h240, 32'h340, INC_S | WD4 | 32'd12);
    run_chain(32'h160);
    check("R4 fixed dest write 0", log_addr[5], 32'h340);
    check("R4 fixed dest write 2", log_addr[9], 32'h340);
    check("R4 source advanced", log_addr[8], 32'h248);
    check("R4 last word lands", get_word(32'h340), get_word(32'h248));

    // zero length
    desc(32'h1E0, 32'h1, 32'h240, 32'h380, INC_S | INC_T | IE_E);
    run_chain(32'h1E0);
    check("R13 only descriptor reads", nlog, 32'd4);
    rrd(3'd0, s);
    check("R13 end flag on empty descriptor", s, 32'hC);
    rwr(3'd0, 32'h4);

    // bus errors
    desc(32'h140, 32'h1, 32'h900, 32'hA00, INC_S | INC_T | WD4 | 32'd8);
    inject = 1'b1; err_addr = 32'h900;
    run_chain(32'h140);
    rrd(3'd0, s);
    check("R7 data read error status", s, 32'h9);
    check("R7 error irq", 32'(irq), 32'h1);
    rwr(3'd0, 32'h1);
    err_addr = 32'h144;
    run_chain(32'h140);
    check("R7 fetch stopped at error", nlog, 32'd2);
    rrd(3'd0, s);
    check("R7 fetch error status", s, 32'h9);
    rwr(3'd0, 32'h1);
    inject = 1'b0;

    // request-paced transfer
    put_word(32'h900, 32'hA5C3_1E77);
    desc(32'h180, 32'h1, 32'h900, 32'hB00, INC_T | PC_S | BU8 | WD4 | 32'd16);
    nlog = 0;
    rwr(3'd1, 32'h180);
    rwr(3'd0, RUN);
    repeat (20) @(negedge clk);
    check("R8 no beats without request", nlog, 32'd4);
    rrd(3'd0, s);
    check("R14 pending low without request", s, 32'h8000_0000);
    @(negedge clk); src_req = 1'b1; reg_addr = 3'd0; #1;
    check("R14 pending with request", reg_rdata, 32'h8000_0100);
    @(negedge clk); src_req = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 one burst per request", count_writes(), 32'd2);
    @(negedge clk); src_req = 1'b1;
    @(negedge clk); src_req = 1'b0;
    wait_stop();
    check("R8 second burst completes", count_writes(), 32'd4);
    check("R8 paced data", get_word(32'hB0C), 32'hA5C3_1E77);

    // abort and ignored pointer write
    desc(32'h1C0, 32'h1, 32'h900, 32'hB40, INC_T | PC_T | WD4 | 32'd8);
    nlog = 0;
    rwr(3'd1, 32'h1C0);
    rwr(3'd0, RUN);
    repeat (20) @(negedge clk);
    rwr(3'd1, 32'h500);
    rrd(3'd1, s);
    check("R10 pointer write ignored while running", s, 32'h1);
    rwr(3'd0, 32'h0);
    rrd(3'd0, s);
    check("R9 abort stops channel", s, 32'h8);
    n0 = nlog;
    repeat (20) @(negedge clk);
    check("R9 no requests after abort", nlog, n0);
    check("R9 mem_req low", 32'(mem_req), 32'h0);

    // register-direct transfer
    rwr(3'd2, 32'h600);
    rwr(3'd3, 32'h700);
    rwr(3'd4, INC_S | INC_T | WD4 | IE_E | 32'd8);
    nlog = 0;
    rwr(3'd0, 32'hC000_0000);
    wait_stop();
    check("R11 first access is data read", log_addr[0], 32'h600);
    check("R11 no descriptor reads", nlog, 32'd4);
    check("R11 data copied", get_word(32'h704), get_word(32'h604));
    rrd(3'd0, s);
    check("R11 status after direct run", s, 32'h4000_000C);
    rwr(3'd0, 32'h4);

    // stop interrupt enable
    rwr(3'd0, 32'h2000_0000);
    check("R12 irq while stopped and enabled", 32'(irq), 32'h1);
    rwr(3'd0, 32'h0);
    check("R12 irq off when disabled", 32'(irq), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule